// File: doc/BRIEF.md
# Serial Memory Read Address Engine

This block serves the read side of a two-wire serial memory. Once the bus front end has accepted a device word with the read direction bit set, the block fetches the byte at its address pointer from the memory array. It then hands that byte out one bit per shift request, most significant bit first. After the eighth bit it lets go of the data line and waits for the master's ninth-bit answer. An acknowledge of zero starts the next byte at once. A not-acknowledge leaves the line released until a stop arrives.

The address pointer belongs to this block. The write sequencer loads it at the end of a data-less write address phase, and a read that follows then returns the byte at that address (a random read). A read with no load before it continues from wherever the pointer was left (a current-address read). The pointer advances by one each time a byte is fetched. It runs across the whole array and wraps to zero after the last location, so a sequential read can go on indefinitely. The array depth is a parameter.

The array is outside the block and is read combinationally. The block drives the array address and receives the data byte back in the same cycle.

Top module: `rd_engine`

## Requirements
- R1: After reset, `tx_drive` is 0, `tx_bit` is 1 (line released) and the pointer, seen on `mem_raddr`, is 0.
- R2: A `rd_start` pulse fetches the byte at the pointer. From the next cycle `tx_drive` is 1, `tx_byte` holds that byte and `tx_bit` shows bit 7. Each `shift_tick` moves `tx_bit` one bit lower, down to bit 0.
- R3: Every byte fetch advances the pointer by one, whether or not the master acknowledges the byte. A later current-address read therefore starts at the last byte sent plus one.
- R4: In the acknowledge slot, `ack_valid` with `ack_bit` = 0 fetches the byte at the pointer. The block drives that byte from the next cycle, starting with bit 7.
- R5: A fetch at address DEPTH-1 sets the pointer to 0, and a sequential read goes on from address 0.
- R6: In the acknowledge slot, `ack_valid` with `ack_bit` = 1 releases the line and sends no more data. Later `shift_tick` or acknowledge pulses neither drive the line nor move the pointer until `stop_det` or `rd_start`.
- R7: `stop_det` in any state ends the read: from the next cycle `tx_drive` is 0 and `tx_bit` is 1.
- R8: An `addr_load` pulse sets the pointer to `addr_load_val` and ends any read in progress. The next `rd_start` returns the byte at that address.
- R9: After the eighth `shift_tick` of a byte, `tx_drive` is 0 and the pointer does not move until the acknowledge slot is answered.
- R10: While a byte is being shifted, `ack_valid` has no effect: the byte is completed unchanged and the pointer holds still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | Pulse: the front end has accepted a read device word |
| addr_load | input | 1 | Pulse: the write sequencer sets the pointer |
| addr_load_val | input | AW | Address to load |
| shift_tick | input | 1 | Pulse: the front end has moved one bit out |
| ack_valid | input | 1 | Pulse: the master's ninth bit has been sampled |
| ack_bit | input | 1 | Sampled ninth bit (0 = acknowledge) |
| stop_det | input | 1 | Pulse: stop condition detected |
| mem_raddr | output | AW | Array read address (the pointer) |
| mem_rdata | input | 8 | Array data at `mem_raddr`, combinational |
| tx_bit | output | 1 | Bit to place on the line (1 when released) |
| tx_drive | output | 1 | 1 while a data bit is being driven |
| tx_byte | output | 8 | The byte currently being sent |

## Verification
The embedded assertions take the input pulses as one-cycle events from a front end that keeps to the bus order. `addr_load` never comes in the same cycle as `rd_start`. `mem_rdata` always reflects `mem_raddr` in the same cycle. The bench drives every pulse for exactly one clock on the falling edge, and it never overlaps a load with a read start. Its array model is combinational and indexed by `mem_raddr`, so each fetch sees the current address.

// File: rtl/rd_engine_pkg.sv
package rd_engine_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_SEND = 2'd1,
        RS_ACKW = 2'd2,
        RS_HOLD = 2'd3
    } rd_state_e;

    typedef struct packed {
        logic fetch;
        logic shift;
        logic drive;
    } rd_ctl_t;

    function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/rd_ptr.sv
module rd_ptr #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    output logic [AW-1:0] ptr
);
    import rd_engine_pkg::*;

    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (load)
            ptr_q <= load_val;
        else if (adv)
            ptr_q <= AW'(wrap_inc(32'(ptr_q), DEPTH));
    end

    assign ptr = ptr_q;

    // R8
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> ptr_q == $past(load_val)) else $error("pointer load");

    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && ptr_q == AW'(DEPTH - 1)) |=> ptr_q == '0) else $error("pointer wrap");

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && ptr_q != AW'(DEPTH - 1)) |=> ptr_q == $past(ptr_q) + AW'(1)) else $error("pointer step");

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(ptr_q)) else $error("pointer hold");

endmodule

// File: rtl/rd_shifter.sv
module rd_shifter
    import rd_engine_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              shift,
    output logic              bit_o,
    output logic              last_o,
    output logic [BYTE_W-1:0] byte_o
);
    logic [BYTE_W-1:0]    sh_q;
    logic [BYTE_W-1:0]    byte_q;
    logic [BIT_CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            byte_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            sh_q   <= din;
            byte_q <= din;
            cnt_q  <= '0;
        end else if (shift) begin
            sh_q   <= {sh_q[BYTE_W-2:0], 1'b1};
            cnt_q  <= cnt_q + BIT_CNT_W'(1);
        end
    end

    assign bit_o  = sh_q[BYTE_W-1];
    assign last_o = (cnt_q == BIT_CNT_W'(BYTE_W - 1));
    assign byte_o = byte_q;

    // R2
    sh_first_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> bit_o == $past(din[BYTE_W-1])) else $error("first bit");

    // R2
    sh_next_chk: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> bit_o == $past(sh_q[BYTE_W-2])) else $error("next bit");

endmodule

// File: rtl/rd_ctrl.sv
module rd_ctrl
    import rd_engine_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rd_start,
    input  logic    addr_load,
    input  logic    stop_det,
    input  logic    shift_tick,
    input  logic    ack_valid,
    input  logic    ack_bit,
    input  logic    last_bit,
    output rd_ctl_t ctl
);
    rd_state_e state_q, state_d;
    logic      abort;
    logic      ack_go;

    assign abort  = addr_load || stop_det;
    assign ack_go = (state_q == RS_ACKW) && ack_valid && !ack_bit;

    always_comb begin
        ctl.fetch = !abort && (rd_start || ack_go);
        ctl.shift = !abort && !rd_start && (state_q == RS_SEND) && shift_tick;
        ctl.drive = (state_q == RS_SEND);
    end

    always_comb begin
        state_d = state_q;
        if (abort)
            state_d = RS_IDLE;
        else if (ctl.fetch)
            state_d = RS_SEND;
        else begin
            case (state_q)
                RS_SEND: if (shift_tick && last_bit) state_d = RS_ACKW;
                RS_ACKW: if (ack_valid)              state_d = RS_HOLD;
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= RS_IDLE;
        else
            state_q <= state_d;
    end

    // R7
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> state_q == RS_IDLE) else $error("stop not honoured");

    // R4
    ack_next_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == RS_ACKW && ack_valid && !ack_bit && !abort) |=> state_q == RS_SEND) else $error("ack not followed");

    // R6
    nack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == RS_ACKW && ack_valid && ack_bit && !abort && !rd_start) |=> state_q == RS_HOLD) else $error("nack not held");

    // R6
    hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == RS_HOLD && !rd_start) |-> !ctl.fetch && !ctl.shift) else $error("activity in hold");

    // R9
    byte_end_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.shift && last_bit) |=> state_q == RS_ACKW) else $error("ack slot missed");

    // R10
    send_noack_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == RS_SEND && !rd_start) |-> !ctl.fetch) else $error("fetch mid byte");

endmodule

// File: rtl/rd_engine.sv
module rd_engine
    import rd_engine_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start,
    input  logic              addr_load,
    input  logic [AW-1:0]     addr_load_val,
    input  logic              shift_tick,
    input  logic              ack_valid,
    input  logic              ack_bit,
    input  logic              stop_det,
    output logic [AW-1:0]     mem_raddr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              tx_bit,
    output logic              tx_drive,
    output logic [BYTE_W-1:0] tx_byte
);
    rd_ctl_t ctl;
    logic    sh_bit;
    logic    sh_last;

    rd_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rd_start   (rd_start),
        .addr_load  (addr_load),
        .stop_det   (stop_det),
        .shift_tick (shift_tick),
        .ack_valid  (ack_valid),
        .ack_bit    (ack_bit),
        .last_bit   (sh_last),
        .ctl        (ctl)
    );

    rd_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (addr_load),
        .load_val (addr_load_val),
        .adv      (ctl.fetch),
        .ptr      (mem_raddr)
    );

    rd_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (ctl.fetch),
        .din    (mem_rdata),
        .shift  (ctl.shift),
        .bit_o  (sh_bit),
        .last_o (sh_last),
        .byte_o (tx_byte)
    );

    assign tx_drive = ctl.drive;
    assign tx_bit   = ctl.drive ? sh_bit : 1'b1;

    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_drive |-> tx_bit) else $error("line not released");

endmodule

// File: tb/rd_engine_tb.sv
module rd_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 256;
    localparam int AW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_start = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_load_val = '0;
    logic          shift_tick = 1'b0;
    logic          ack_valid = 1'b0;
    logic          ack_bit = 1'b1;
    logic          stop_det = 1'b0;
    logic [AW-1:0] mem_raddr;
    logic [7:0]    mem_rdata;
    logic          tx_bit;
    logic          tx_drive;
    logic [7:0]    tx_byte;

    logic [7:0] bmem [DEPTH];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int exp_ptr = 0;
    logic [7:0] exp_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = bmem[mem_raddr];

    rd_engine #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .rd_start(rd_start), .addr_load(addr_load),
        .addr_load_val(addr_load_val), .shift_tick(shift_tick),
        .ack_valid(ack_valid), .ack_bit(ack_bit), .stop_det(stop_det),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .tx_bit(tx_bit),
        .tx_drive(tx_drive), .tx_byte(tx_byte)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int inc(int p);
        return (p == DEPTH - 1) ? 0 : p + 1;
    endfunction

    task automatic fetch_model();
        exp_data = bmem[exp_ptr];
        exp_ptr  = inc(exp_ptr);
    endtask

    task automatic load_addr(int a);
        addr_load = 1'b1; addr_load_val = AW'(a);
        @(negedge clk);
        addr_load = 1'b0;
        exp_ptr = a;
        chk(mem_raddr == AW'(a), "R8", "pointer after load", int'(mem_raddr), a);
    endtask

    task automatic start_read();
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        fetch_model();
        chk(tx_drive == 1'b1, "R2", "drive after start", int'(tx_drive), 1);
        chk(mem_raddr == AW'(exp_ptr), "R3", "pointer after fetch", int'(mem_raddr), exp_ptr);
    endtask

    task automatic get_byte(bit noisy, string req);
        logic [7:0] got;
        chk(tx_byte == exp_data, req, "tx_byte", int'(tx_byte), int'(exp_data));
        for (int i = 7; i >= 0; i--) begin
            got[i] = tx_bit;
            shift_tick = 1'b1;
            if (noisy) begin ack_valid = 1'b1; ack_bit = 1'b0; end
            @(negedge clk);
            shift_tick = 1'b0; ack_valid = 1'b0; ack_bit = 1'b1;
        end
        chk(got == exp_data, req, "serial byte", int'(got), int'(exp_data));
        chk(tx_drive == 1'b0 && tx_bit == 1'b1, "R9", "released in ack slot", int'(tx_drive), 0);
        chk(mem_raddr == AW'(exp_ptr), "R9", "pointer in ack slot", int'(mem_raddr), exp_ptr);
    endtask

    task automatic send_ack(bit v);
        ack_valid = 1'b1; ack_bit = v;
        @(negedge clk);
        ack_valid = 1'b0; ack_bit = 1'b1;
        if (!v) begin
            fetch_model();
            chk(tx_drive == 1'b1, "R4", "drive after ack", int'(tx_drive), 1);
        end else begin
            chk(tx_drive == 1'b0, "R6", "released after nack", int'(tx_drive), 0);
        end
    endtask

    task automatic send_stop();
        stop_det = 1'b1;
        @(negedge clk);
        stop_det = 1'b0;
        chk(tx_drive == 1'b0 && tx_bit == 1'b1, "R7", "released after stop", int'(tx_drive), 0);
    endtask

    task automatic read_body(int n, string req);
        for (int k = 0; k < n; k++) begin
            get_byte(1'b0, req);
            send_ack((k == n - 1) ? 1'b1 : 1'b0);
        end
        send_stop();
    endtask

    task automatic t_reset();
        chk(tx_drive == 1'b0, "R1", "reset drive", int'(tx_drive), 0);
        chk(tx_bit == 1'b1, "R1", "reset bit", int'(tx_bit), 1);
        chk(mem_raddr == '0, "R1", "reset pointer", int'(mem_raddr), 0);
    endtask

    task automatic t_random(int a, int n);
        load_addr(a);
        start_read();
        read_body(n, "R8");
    endtask

    task automatic t_current(int n);
        start_read();
        read_body(n, "R3");
    endtask

    task automatic t_wrap();
        load_addr(DEPTH - 2);
        start_read();
        for (int k = 0; k < 4; k++) begin
            get_byte(1'b0, "R5");
            send_ack((k == 3) ? 1'b1 : 1'b0);
        end
        chk(mem_raddr == AW'(2), "R5", "pointer after wrap", int'(mem_raddr), 2);
        send_stop();
    endtask

    task automatic t_hold();
        load_addr(40);
        start_read();
        get_byte(1'b0, "R6");
        send_ack(1'b1);
        for (int k = 0; k < 3; k++) begin
            shift_tick = 1'b1; ack_valid = 1'b1; ack_bit = 1'b0;
            @(negedge clk);
            shift_tick = 1'b0; ack_valid = 1'b0; ack_bit = 1'b1;
            chk(tx_drive == 1'b0, "R6", "no data in hold", int'(tx_drive), 0);
            chk(mem_raddr == AW'(exp_ptr), "R6", "pointer still in hold", int'(mem_raddr), exp_ptr);
        end
        send_stop();
        start_read();
        read_body(1, "R3");
    endtask

    task automatic t_stop_mid();
        load_addr(100);
        start_read();
        for (int k = 0; k < 3; k++) begin
            shift_tick = 1'b1;
            @(negedge clk);
            shift_tick = 1'b0;
        end
        send_stop();
        shift_tick = 1'b1;
        @(negedge clk);
        shift_tick = 1'b0;
        chk(tx_drive == 1'b0, "R7", "idle ignores shift", int'(tx_drive), 0);
        chk(mem_raddr == AW'(101), "R3", "pointer after aborted byte", int'(mem_raddr), 101);
        start_read();
        read_body(2, "R3");
    endtask

    task automatic t_noisy();
        load_addr(7);
        start_read();
        get_byte(1'b1, "R10");
        chk(mem_raddr == AW'(8), "R10", "pointer after noisy byte", int'(mem_raddr), 8);
        send_ack(1'b0);
        get_byte(1'b0, "R4");
        send_ack(1'b1);
        send_stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) bmem[i] = 8'(i * 37 + 5) ^ 8'(i >> 3);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_random(20, 3);
        t_current(2);
        t_wrap();
        t_current(1);
        t_hold();
        t_stop_mid();
        t_noisy();
        t_random(255, 1);
        t_current(1);
        finish_run();
    end

endmodule